// File: doc/BRIEF.md
# Masked-Write Word RAM

This block is a word-addressable storage array. It has one synchronous write port and one read port, and both run in a single clock domain. Each write carries an address, a data word and a per-chunk enable mask. The data word is split into equal chunks of `GRAN` bits, so any subset of those sub-fields can be updated at the addressed word without touching the others. Power-on contents come from a packed parameter vector of `INIT_COUNT` words. Any word beyond that list starts at zero.

The read port works in one of two modes, chosen by a parameter:

- **Registered mode:** the read port has one cycle of latency. Its output register loads only while read enable is high.
- **Combinational mode:** the read data follows the address directly, and the read enable has no effect.

A second parameter selects what a read of the address being written returns in that same cycle: the newly written word or the word stored before the write. Elaboration is rejected in three cases:

- the chunk size is larger than the word,
- the chunk size does not divide the word exactly,
- a combinational port is asked to return the old word.

Top module: `masked_ram`

## Requirements
- R1: At power-on, word i holds bits [i*WIDTH +: WIDTH] of INIT_VEC when i < INIT_COUNT, and zero otherwise.
- R2: A write takes effect at the clock edge where it is presented. A read of that address presented in the following cycle returns the written word.
- R3: Bit c of `wr_mask` enables data bits [c*GRAN +: GRAN]. Chunks whose bit is 0 keep their stored value, and a mask of all zeros changes nothing. A write to one address leaves every other address unchanged.
- R4: In registered mode, when `rd_en` is 1 at a clock edge, `rd_data` shows the word at `rd_addr` after that edge.
- R5: In registered mode, when `rd_en` is 0 at a clock edge, `rd_data` keeps its previous value.
- R6: In registered transparent mode, a read of the address being written in the same cycle returns the enabled new chunks merged with the unchanged old chunks.
- R7: In registered non-transparent mode, a read of the address being written in the same cycle returns the word stored before the write.
- R8: In combinational mode, `rd_data` follows `rd_addr` with no clock. While an address is being written, a read of it shows the old word until the edge and the new word after it.
- R9: Reset (`rst_n` low) clears the registered `rd_data` to zero and leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| wr_addr | input | AW | Write address |
| wr_data | input | WIDTH | Write data word |
| wr_mask | input | WIDTH/GRAN | Per-chunk write enable |
| rd_en | input | 1 | Read enable (registered mode only) |
| rd_addr | input | AW | Read address |
| rd_data | output | WIDTH | Read data |

## Verification
The hardest case to reach is a read that collides with a partially masked write to the same address. In that case the two read modes must disagree chunk by chunk, and the combinational port must change value exactly at the edge. The bench sweeps every address against all sixteen mask patterns, each with a simultaneous read of the same address. Three instances share the stimulus, one for each read variant. Every collision is checked against the old word, the merged word and the edge-timed combinational value, all computed in the bench.

// File: rtl/masked_ram.sv
module masked_ram #(
  parameter int WIDTH       = 32,
  parameter int DEPTH       = 64,
  parameter int GRAN        = WIDTH,
  parameter bit REGISTERED  = 1'b1,
  parameter bit TRANSPARENT = 1'b1,
  parameter int INIT_COUNT  = 0,
  parameter logic [((INIT_COUNT > 0) ? INIT_COUNT : 1)*WIDTH-1:0] INIT_VEC = '0,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CHUNKS = WIDTH / GRAN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [CHUNKS-1:0] wr_mask,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WIDTH-1:0]  rd_data
);

  if (GRAN > WIDTH || (WIDTH % GRAN) != 0) begin : g_bad_gran
    $error("masked_ram: GRAN must divide WIDTH and not exceed it");
  end
  if (!REGISTERED && !TRANSPARENT) begin : g_bad_mode
    $error("masked_ram: a combinational read port must be transparent");
  end

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] bitmask, stored, fwd, merged;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = (i < INIT_COUNT) ? INIT_VEC[i*WIDTH +: WIDTH] : '0;
  end

  for (genvar c = 0; c < CHUNKS; c++) begin : g_mask
    assign bitmask[c*GRAN +: GRAN] = {GRAN{wr_mask[c]}};
  end

  wire wr_ok = int'(wr_addr) < DEPTH;
  wire rd_ok = int'(rd_addr) < DEPTH;

  always @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= (mem[wr_addr] & ~bitmask) | (wr_data & bitmask);
  end

  assign stored = rd_ok ? mem[rd_addr] : '0;
  assign fwd    = (wr_ok && rd_ok && wr_addr == rd_addr) ? bitmask : '0;
  assign merged = (stored & ~fwd) | (wr_data & fwd);

  if (REGISTERED) begin : g_reg
    logic [WIDTH-1:0] rd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= TRANSPARENT ? merged : stored;
    end
    assign rd_data = rd_q;
  end else begin : g_comb
    wire unused_ctrl = &{1'b0, rd_en, rst_n, merged};
    assign rd_data = stored;
  end

endmodule

// File: rtl/masked_ram_checker.sv
module masked_ram_checker #(
  parameter int WIDTH       = 32,
  parameter int DEPTH       = 64,
  parameter int GRAN        = WIDTH,
  parameter bit REGISTERED  = 1'b1,
  parameter bit TRANSPARENT = 1'b1,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CHUNKS = WIDTH / GRAN
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     wr_addr,
  input logic [WIDTH-1:0]  wr_data,
  input logic [CHUNKS-1:0] wr_mask,
  input logic              rd_en,
  input logic [AW-1:0]     rd_addr,
  input logic [WIDTH-1:0]  rd_data
);

  if (REGISTERED) begin : g_reg_props
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

    a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == $past(wr_addr) && $past(wr_mask) == '1 &&
       int'($past(wr_addr)) < DEPTH && !(wr_mask != '0 && wr_addr == rd_addr))
      |=> rd_data == $past(wr_data, 2));

    if (TRANSPARENT) begin : g_tr
      a_r6_new_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_mask == '1 && wr_addr == rd_addr && int'(wr_addr) < DEPTH)
        |=> rd_data == $past(wr_data));
    end
  end else begin : g_comb_props
    a_r8_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_mask) == '1 && rd_addr == $past(wr_addr) && int'(rd_addr) < DEPTH)
      |-> rd_data == $past(wr_data));
  end

endmodule

bind masked_ram masked_ram_checker #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .GRAN(GRAN),
  .REGISTERED(REGISTERED), .TRANSPARENT(TRANSPARENT)
) u_checker (.*);

// File: tb/masked_ram_bench.sv
module masked_ram_bench;
  localparam int W = 16, G = 4, D = 8, AW = 3, NC = W / G;
  localparam logic [3*W-1:0] INIT = {16'hC0DE, 16'hBEEF, 16'h1234};

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [W-1:0] wr_data;
  logic [NC-1:0] wr_mask;
  logic rd_en;
  logic [W-1:0] q_tr, q_op, q_cb;

  always #5 clk = ~clk;

  masked_ram #(.WIDTH(W), .DEPTH(D), .GRAN(G), .REGISTERED(1'b1), .TRANSPARENT(1'b1),
               .INIT_COUNT(3), .INIT_VEC(INIT)) u_masked_ram (
    .clk, .rst_n, .wr_addr, .wr_data, .wr_mask, .rd_en, .rd_addr, .rd_data(q_tr));
  masked_ram #(.WIDTH(W), .DEPTH(D), .GRAN(G), .REGISTERED(1'b1), .TRANSPARENT(1'b0),
               .INIT_COUNT(3), .INIT_VEC(INIT)) u_opaque (
    .clk, .rst_n, .wr_addr, .wr_data, .wr_mask, .rd_en, .rd_addr, .rd_data(q_op));
  masked_ram #(.WIDTH(W), .DEPTH(D), .GRAN(G), .REGISTERED(1'b0), .TRANSPARENT(1'b1),
               .INIT_COUNT(3), .INIT_VEC(INIT)) u_comb (
    .clk, .rst_n, .wr_addr, .wr_data, .wr_mask, .rd_en, .rd_addr, .rd_data(q_cb));

  int total = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] model [D];

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw, logic [NC-1:0] m);
    logic [W-1:0] r = old;
    for (int c = 0; c < NC; c++) if (m[c]) r[c*G +: G] = nw[c*G +: G];
    return r;
  endfunction

  function automatic logic [W-1:0] pattern(int a, int m);
    return {4'(a), 4'(m), 4'(~a), 4'(a + m + 3)};
  endfunction

  task automatic read_at(int a, string req);
    @(negedge clk);
    wr_mask = '0; rd_en = 1'b1; rd_addr = AW'(a);
    #1 check("R8", "comb read", q_cb, model[a]);
    @(posedge clk); #1;
    check(req, "transparent read", q_tr, model[a]);
    check(req, "opaque read", q_op, model[a]);
  endtask

  initial begin
    logic [W-1:0] old_w, new_w, hold_t, hold_o;
    rst_n = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0; wr_mask = '0; rd_en = 1'b1;
    for (int i = 0; i < D; i++) model[i] = (i < 3) ? INIT[i*W +: W] : '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9", "reset transparent", q_tr, '0);
    check("R9", "reset opaque", q_op, '0);
    @(negedge clk) rst_n = 1'b1;

    for (int a = 0; a < D; a++) read_at(a, "R1");

    for (int a = 0; a < D; a++)
      for (int m = 0; m < (1 << NC); m++) begin
        @(negedge clk);
        wr_addr = AW'(a); rd_addr = AW'(a); rd_en = 1'b1;
        wr_data = pattern(a, m); wr_mask = NC'(m);
        old_w = model[a];
        new_w = merge(old_w, wr_data, wr_mask);
        #1 check("R8", "comb before edge", q_cb, old_w);
        @(posedge clk); #1;
        wr_mask = '0;
        model[a] = new_w;
        check("R6", "collision merged", q_tr, new_w);
        check("R7", "collision old", q_op, old_w);
        check("R8", "comb after edge", q_cb, new_w);
      end

    for (int a = 0; a < D; a++) begin
      @(negedge clk);
      wr_addr = AW'(a); wr_data = ~pattern(a, 9); wr_mask = '1;
      rd_addr = AW'((a + 1) % D); rd_en = 1'b1;
      @(posedge clk); #1;
      wr_mask = '0;
      check("R3", "other address untouched", q_tr, model[(a + 1) % D]);
      model[a] = ~pattern(a, 9);
      read_at(a, "R2");
      read_at((a + 1) % D, "R4");
    end

    for (int a = 0; a < D; a += 3) begin
      @(negedge clk);
      hold_t = q_tr; hold_o = q_op;
      rd_en = 1'b0; rd_addr = AW'(a);
      wr_addr = AW'(a); wr_data = pattern(a, 5) ^ 16'h5A5A; wr_mask = '1;
      @(posedge clk); #1;
      wr_mask = '0;
      model[a] = pattern(a, 5) ^ 16'h5A5A;
      check("R5", "hold transparent", q_tr, hold_t);
      check("R5", "hold opaque", q_op, hold_o);
      read_at(a, "R2");
    end

    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R9", "mid reset clears", q_tr, '0);
    @(negedge clk) rst_n = 1'b1;
    for (int a = 0; a < D; a++) read_at(a, "R9");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule